// File: doc/BRIEF.md
# Pipelined Converter Digital Correction

This block is the digital back end of a nine-stage pipelined analog-to-digital converter. Stages one to eight each resolve a redundant 1.5-bit digit from a pair of comparators, and stage nine is a 2-bit flash. Each stage doubles its residue before the next stage sees it, so neighbouring stage weights differ by two and each 1.5-bit digit overlaps its neighbour by one bit. That overlap lets the adder absorb comparator offsets without leaving a gap in the output code range.

A sample moves forward one stage every half sample period, so the decisions for one sample reach the block at staggered times. The block runs on a tick clock at twice the sample rate. Each decision goes into a shift chain whose depth puts all nine digits for one sample side by side. The aligned digits are decoded, weighted, summed and clamped. The 10-bit result is registered at a sample edge, five sample periods after the sampling edge, and a one-tick strobe marks each new result.

Top module: `adc_dig_corr`

## Requirements
- R1: Each comparator pair of stages 1 to 8, written (upper, lower), counts as a digit equal to the number of set comparators: (0,0) is 0, (0,1) is 1 and (1,1) is 2.
- R2: The output code is the sum of digit k times 2^(9-k) for k from 1 to 8, plus the 2-bit final-stage code with weight 1.
- R3: The illegal pair (1,0), upper set and lower clear, counts as digit 1 and is summed like any legal digit.
- R4: Sampling edges are the tick edges 0, 2, 4 and so on after reset is released. For a sample taken at edge s, stage k's pair is captured at edge s+k and the final code at edge s+9. The result appears on code_out after edge s+10, which is five sample periods later.
- R5: After reset release, code_vld stays low until the first result. It first rises after tick edge 10.
- R6: Once the pipeline has filled, code_vld is high for exactly one tick per sample and low on the tick between. It is high after every even tick edge from 10 onward.
- R7: code_out holds its value for both ticks of a sample period.
- R8: While reset is held, code_out is 0 and code_vld is 0, whatever the decision inputs carry.
- R9: Every code from 0 to 1023 can be reached from some set of stage decisions, so the correction leaves no missing code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock at twice the sample rate; sampling edges are the even ticks after reset |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_hi | input | 8 | Upper comparator of stages 1..8, bit k-1 for stage k |
| cmp_lo | input | 8 | Lower comparator of stages 1..8, bit k-1 for stage k |
| fin_code | input | 2 | Final-stage flash code, 0..3 |
| code_out | output | 10 | Corrected conversion result |
| code_vld | output | 1 | One-tick strobe, high when code_out carries a new result |

## Verification
The assertions assume that reset is held for at least one tick edge, so the strobe and the tick counter in the checker start from a known state. They say nothing about code values. Code values are left to the bench. The bench presents each stage's pair for exactly the two ticks that begin at that stage's capture edge. It sweeps every target code from 0 to 1023 through a greedy digit split, then runs hashed comparator patterns that include the illegal pair, so the inputs always follow the staggered arrival order of R4.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the pipelined-converter correction back end.
// Assumes comparator pairs arrive as (upper, lower) thermometer bits.
package adc_corr_pkg;

    // Total number of converter stages, including the final flash.
    localparam int unsigned CORR_STAGES = 9;
    // Resolution of the final flash stage in bits.
    localparam int unsigned CORR_FIN_W  = 2;

    typedef logic [1:0] cmp_pair_t;

    // Count of set comparators: 00 -> 0, 01 -> 1, 10 -> 1, 11 -> 2.
    function automatic cmp_pair_t pair_count(input logic upper, input logic lower);
        return {upper & lower, upper ^ lower};
    endfunction

endpackage

// File: rtl/corr_delay.sv
`timescale 1ns/1ps
// Fixed-depth shift chain that holds one stage's decision until the
// decisions of later stages for the same sample have caught up.
// Assumes DEPTH >= 1. Every register clears on reset.
module corr_delay #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [DEPTH];

    // Shift the decision one tick further down the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(DEPTH); i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[DEPTH-1];

endmodule

// File: rtl/corr_timing.sv
`timescale 1ns/1ps
// Tick phase and pipeline-fill tracking. The first tick edge after reset
// release is a sampling edge, and sampling edges then alternate with
// mid-period edges. `filled` rises once LAT_SMP sampling edges have passed.
module corr_timing #(
    parameter int unsigned LAT_SMP = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic samp,
    output logic filled
);

    localparam int unsigned CW = $clog2(LAT_SMP + 1);

    logic          ph;
    logic [CW-1:0] cnt;

    // Alternate between the sampling phase and the mid-period phase.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    // Count sampling edges until the pipeline depth is covered.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt <= '0;
        else if (!ph && (cnt != CW'(LAT_SMP)))      cnt <= cnt + CW'(1);
    end

    assign samp   = ~ph;
    assign filled = (cnt == CW'(LAT_SMP));

endmodule

// File: rtl/corr_merge.sv
`timescale 1ns/1ps
// Combinational recombination of aligned redundant digits. Stage j
// (0-based) carries weight 2^(FIN_W-1+N_RED-1-j), and the final code has
// weight 1. The sum is clamped to the output range as a guard.
module corr_merge
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_RED = 8,
    parameter int unsigned FIN_W = 2,
    parameter int unsigned OUT_W = N_RED + FIN_W
) (
    input  logic [N_RED-1:0] hi,
    input  logic [N_RED-1:0] lo,
    input  logic [FIN_W-1:0] fin,
    output logic [OUT_W-1:0] code
);

    localparam int unsigned SUM_W = OUT_W + 1;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);

    logic [SUM_W-1:0] acc;

    // Weighted sum of all decoded digits.
    always_comb begin
        acc = SUM_W'(fin);
        for (int j = 0; j < int'(N_RED); j++) begin
            acc = acc + (SUM_W'(pair_count(hi[j], lo[j])) << (FIN_W - 1 + N_RED - 1 - j));
        end
    end

    // Clamp into the representable code range.
    always_comb begin
        if (acc > MAXV) code = MAXV[OUT_W-1:0];
        else            code = acc[OUT_W-1:0];
    end

endmodule

// File: rtl/adc_dig_corr.sv
`timescale 1ns/1ps
// Digital correction for a pipelined converter. Runs on a tick clock at
// twice the sample rate. Deskews the staggered stage decisions, merges the
// redundant digits and registers the result on sampling edges.
// Assumes stage k's pair for a sample taken at edge s is present at edge s+k.
module adc_dig_corr
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_STG = CORR_STAGES,
    parameter int unsigned FIN_W = CORR_FIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STG-2:0]     cmp_hi,
    input  logic [N_STG-2:0]     cmp_lo,
    input  logic [FIN_W-1:0]     fin_code,
    output logic [N_STG+FIN_W-2:0] code_out,
    output logic                 code_vld
);

    localparam int unsigned N_RED   = N_STG - 1;
    localparam int unsigned OUT_W   = N_RED + FIN_W;
    localparam int unsigned TICKS   = N_STG + 1;
    localparam int unsigned LAT_SMP = TICKS / 2;

    logic [N_RED-1:0] al_hi;
    logic [N_RED-1:0] al_lo;
    logic [FIN_W-1:0] al_fin;
    logic [OUT_W-1:0] merged;
    logic             samp;
    logic             filled;

    // One chain per redundant stage; earlier stages wait longer.
    for (genvar j = 0; j < int'(N_RED); j++) begin : g_dsk
        logic [1:0] pair_q;
        corr_delay #(.W(2), .DEPTH(N_STG - j)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     ({cmp_hi[j], cmp_lo[j]}),
            .q     (pair_q)
        );
        assign al_hi[j] = pair_q[1];
        assign al_lo[j] = pair_q[0];
    end

    corr_delay #(.W(FIN_W), .DEPTH(1)) u_fin_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fin_code),
        .q     (al_fin)
    );

    corr_merge #(.N_RED(N_RED), .FIN_W(FIN_W), .OUT_W(OUT_W)) u_merge (
        .hi   (al_hi),
        .lo   (al_lo),
        .fin  (al_fin),
        .code (merged)
    );

    corr_timing #(.LAT_SMP(LAT_SMP)) u_tim (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp   (samp),
        .filled (filled)
    );

    // Output latch: new code on sampling edges, strobe once filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= samp & filled;
            if (samp) code_out <= merged;
        end
    end

endmodule

// File: rtl/adc_dig_corr_chk.sv
`timescale 1ns/1ps
// Property checker for adc_dig_corr, attached with bind. Counts ticks since
// reset release itself so the fill window needs no deep $past.
module adc_dig_corr_chk #(
    parameter int unsigned LAT_SMP = 5,
    parameter int unsigned OUT_W   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             code_vld,
    input logic [OUT_W-1:0] code_out
);

    localparam int unsigned FIRST = 2 * LAT_SMP + 1;
    localparam int unsigned LIM   = FIRST + 1;
    localparam int unsigned TW    = $clog2(LIM + 1);

    logic [TW-1:0] tk;

    // Tick edges seen since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                tk <= '0;
        else if (tk != TW'(LIM))   tk <= tk + TW'(1);
    end

    AST_NO_EARLY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> (tk >= TW'(FIRST))); // R5
    AST_FIRST_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tk == TW'(FIRST)) |-> code_vld); // R5
    AST_VLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> !code_vld); // R6
    AST_VLD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tk >= TW'(FIRST) && $past(code_vld, 2)) |-> code_vld); // R6
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> $stable(code_out)); // R7

endmodule

bind adc_dig_corr adc_dig_corr_chk #(.LAT_SMP(LAT_SMP), .OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_vld (code_vld),
    .code_out (code_out)
);

// File: tb/adc_dig_corr_test.sv
`timescale 1ns/1ps
// Bench: greedy-split sweep of all 1024 codes, then hashed comparator
// patterns including the illegal pair. Expected codes are computed here.
module adc_dig_corr_test;

    localparam int NS = 1280;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmp_hi = '0;
    logic [7:0] cmp_lo = '0;
    logic [1:0] fin_code = '0;
    logic [9:0] code_out;
    logic       code_vld;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    adc_dig_corr uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_hi   (cmp_hi),
        .cmp_lo   (cmp_lo),
        .fin_code (fin_code),
        .code_out (code_out),
        .code_vld (code_vld)
    );

    always #5 clk = ~clk;

    function automatic logic [1:0] enc(input int d);
        return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b11;
    endfunction

    function automatic logic [31:0] hsh(input int m);
        logic [31:0] x;
        x = 32'(m) * 32'h9E37_79B1;
        return x ^ (x >> 15);
    endfunction

    // Pair for stage k (1..8) or final code (k = 9) of sample m.
    function automatic logic [1:0] dec_of(input int m, input int k);
        int r;
        int d;
        if (m >= 1024) begin
            logic [31:0] x;
            x = hsh(m);
            return (k == 9) ? x[21:20] : x[2*k +: 2];
        end
        r = m;
        for (int kk = 1; kk <= 8; kk++) begin
            d = r / (1 << (9 - kk));
            if (d > 2) d = 2;
            r = r - d * (1 << (9 - kk));
            if (kk == k) return enc(d);
        end
        return 2'(r);
    endfunction

    function automatic int exp_of(input int m);
        int s;
        logic [1:0] p;
        if (m < 1024) return m;
        s = int'(dec_of(m, 9));
        for (int k = 1; k <= 8; k++) begin
            p = dec_of(m, k);
            s = s + (int'(p[1]) + int'(p[0])) * (1 << (9 - k));
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Drive the inputs that are captured at tick edge n.
    task automatic drive(input int n);
        logic [1:0] p;
        for (int k = 1; k <= 8; k++) begin
            p = (n >= k) ? dec_of((n - k) / 2, k) : 2'b00;
            cmp_hi[k-1] = p[1];
            cmp_lo[k-1] = p[0];
        end
        fin_code = (n >= 9) ? dec_of((n - 9) / 2, 9) : 2'b00;
    endtask

    initial begin
        int m;
        string tg;
        // R8: reset holds outputs at zero despite busy inputs.
        cmp_hi = 8'hFF; cmp_lo = 8'hA5; fin_code = 2'd3;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(code_out == 10'd0, "R8 code", int'(code_out), 0);
        chk(code_vld == 1'b0, "R8 vld", int'(code_vld), 0);
        rst_n = 1'b1;
        drive(0);
        for (int n = 0; n <= 2 * (NS - 1) + 11; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n < 10) begin
                chk(code_vld == 1'b0, "R5 fill", int'(code_vld), 0);
            end else if ((n % 2) == 0) begin
                m = (n - 10) / 2;
                tg = (m < 1024) ? "R1 R2 R4 R9" : "R3 R2 R4";
                chk(code_vld == 1'b1, "R6 strobe", int'(code_vld), 1);
                chk(int'(code_out) == exp_of(m), tg, int'(code_out), exp_of(m));
            end else begin
                m = (n - 11) / 2;
                chk(code_vld == 1'b0, "R6 gap", int'(code_vld), 0);
                chk(int'(code_out) == exp_of(m), "R7 hold", int'(code_out), exp_of(m));
            end
            drive(n + 1);
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
        end
        $finish;
    end

endmodule